// File: doc/BRIEF.md
# Letter Variable Register File

This block stores the integer variables of a small line-oriented interpreter, one per upper-case letter. A microcode sequencer drives a two-bit command each clock. One bit loads a 5-bit index register from a name byte taken from the top of the evaluation stack. The other bit writes the value on the temporary-register input into the entry that the index selects. The read port is combinational and always shows the entry at the current index.

The name byte holds the ASCII code of the letter multiplied by two. The decoder halves it and removes the ASCII bias, so letter A lands in entry 1 and letter Z in entry 26. The store has 32 entries. Entry 0 and entries 27 to 31 are ordinary storage that no letter reaches. They raise no error when they are read or written.

The two command bits may be set together. That is how a sequencer can finish a store-variable step and select the next variable in a single cycle: the write goes to the index held before the edge, and the new index applies from the edge onward.

Top module: `varfile`

## Requirements
- R1: While `rst` is high at a rising edge, every entry and the index register become zero. After reset, `index_o` is 0 and `rd_data` is 0 for every index.
- R2: When `cmd[0]` is 1 at a rising edge, the index becomes the low 5 bits of ((`name_byte` >> 1) − 0x40). Examples: 0x82 ('A'×2) gives 1, 0xB4 ('Z'×2) gives 26, 0x80 gives 0, and 0xFE gives 31.
- R3: The index register changes only at an edge where `cmd[0]` is 1. `name_byte` has no effect at any other time.
- R4: When `cmd[1]` is 1 at a rising edge, `temp_val` is stored in the entry at the current index. It is visible on `rd_data` after that edge.
- R5: With `cmd` = 2'b11, the write uses the index from before the edge, and the index loads the new decoded value at the same edge.
- R6: `rd_data` always equals the stored contents of the entry at `index_o`, with no clock delay.
- R7: Entry 0 and entries 27 to 31 can be written and read like the letter entries, and no error is raised.
- R8: A write changes only the addressed entry. All other entries keep their contents.
- R9: With `cmd` = 2'b00, neither the index nor any entry changes. `temp_val` is ignored whenever `cmd[1]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command bits: bit 0 loads the index, bit 1 writes; 00 holds |
| name_byte | input | 8 | Stack-top byte: twice the ASCII code of the variable letter |
| temp_val | input | 16 | Temporary-register value, the only source of write data |
| index_o | output | 5 | Current index register |
| rd_data | output | 16 | Contents of the entry at the current index |

## Verification
The assertions check these properties on every cycle:
- a load sets the decoded index;
- the index stays still when there is no load;
- a plain write reads back on the next cycle;
- a hold leaves both outputs unchanged;
- a combined command whose new index equals the old one reads back the written value;
- reset clears the outputs.

Some properties need storage state that only a sequence of writes and reads can expose, so only the bench scenarios can show them:
- a combined command writes at the old index;
- the writes reach exactly one entry;
- the unused entries work as plain storage.

The bench covers these with a full sweep of all 32 entries and all 256 name bytes.

// File: rtl/varfile_pkg.sv
package varfile_pkg;

    localparam int VF_DATA_W = 16;
    localparam int VF_IDX_W  = 5;
    localparam int VF_NAME_W = 8;
    localparam int VF_BIAS   = 'h40;

    typedef enum logic [1:0] {
        VF_HOLD       = 2'b00,
        VF_LOAD       = 2'b01,
        VF_WRITE      = 2'b10,
        VF_LOAD_WRITE = 2'b11
    } vf_cmd_e;

    typedef struct packed {
        logic load_idx;
        logic wr_en;
    } vf_ctrl_t;

    function automatic vf_ctrl_t vf_split(input vf_cmd_e c);
        vf_ctrl_t r;
        r.load_idx = (c == VF_LOAD) || (c == VF_LOAD_WRITE);
        r.wr_en    = (c == VF_WRITE) || (c == VF_LOAD_WRITE);
        return r;
    endfunction

endpackage

// File: rtl/varfile_index.sv
module varfile_index
    import varfile_pkg::*;
#(
    parameter int NAME_W = VF_NAME_W,
    parameter int IDX_W  = VF_IDX_W,
    parameter int BIAS   = VF_BIAS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_idx,
    input  logic [NAME_W-1:0] name_byte,
    output logic [IDX_W-1:0]  index_q
);

    localparam logic [NAME_W-1:0] BIAS_V = NAME_W'(BIAS);

    logic [IDX_W-1:0] decoded;

    // Halve the doubled ASCII code and strip the letter bias; wraps modulo the store size.
    always_comb begin
        decoded = IDX_W'((name_byte >> 1) - BIAS_V);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
        end else if (load_idx) begin
            index_q <= decoded;
        end
    end

endmodule

// File: rtl/varfile_store.sv
module varfile_store
    import varfile_pkg::*;
#(
    parameter int DATA_W = VF_DATA_W,
    parameter int IDX_W  = VF_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
        logic hit;
        always_comb hit = wr_en && (wr_idx == IDX_W'(e));
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[e] <= '0;
            end else if (hit) begin
                cells[e] <= wr_data;
            end
        end
    end

    always_comb rd_data = cells[rd_idx];

endmodule

// File: rtl/varfile.sv
module varfile
    import varfile_pkg::*;
#(
    parameter int DATA_W = VF_DATA_W,
    parameter int IDX_W  = VF_IDX_W,
    parameter int NAME_W = VF_NAME_W,
    parameter int BIAS   = VF_BIAS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [NAME_W-1:0] name_byte,
    input  logic [DATA_W-1:0] temp_val,
    output logic [IDX_W-1:0]  index_o,
    output logic [DATA_W-1:0] rd_data
);

    vf_ctrl_t         ctrl;
    logic [IDX_W-1:0] cur_idx;

    always_comb ctrl = vf_split(vf_cmd_e'(cmd));

    varfile_index #(
        .NAME_W (NAME_W),
        .IDX_W  (IDX_W),
        .BIAS   (BIAS)
    ) u_index (
        .clk       (clk),
        .rst       (rst),
        .load_idx  (ctrl.load_idx),
        .name_byte (name_byte),
        .index_q   (cur_idx)
    );

    // The write addresses the index as registered before this edge.
    varfile_store #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl.wr_en),
        .wr_idx  (cur_idx),
        .wr_data (temp_val),
        .rd_idx  (cur_idx),
        .rd_data (rd_data)
    );

    always_comb index_o = cur_idx;

endmodule

// File: rtl/varfile_chk.sv
module varfile_chk #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5,
    parameter int NAME_W = 8,
    parameter int BIAS   = 'h40
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cmd,
    input logic [NAME_W-1:0] name_byte,
    input logic [DATA_W-1:0] temp_val,
    input logic [IDX_W-1:0]  index_o,
    input logic [DATA_W-1:0] rd_data
);

    logic [IDX_W-1:0] expect_idx;
    always_comb expect_idx = IDX_W'(NAME_W'(name_byte >> 1) - NAME_W'(BIAS));

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (index_o == '0 && rd_data == '0)); // R1

    AST_LOAD_DECODES: assert property (@(posedge clk) disable iff (rst)
        cmd[0] |=> index_o == $past(expect_idx)); // R2

    AST_INDEX_STILL: assert property (@(posedge clk) disable iff (rst)
        !cmd[0] |=> $stable(index_o)); // R3

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        cmd == 2'b10 |=> rd_data == $past(temp_val)); // R4

    AST_SAME_IDX_BOTH: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b11 && expect_idx == index_o) |=> rd_data == $past(temp_val)); // R5

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmd == 2'b00 |=> ($stable(rd_data) && $stable(index_o))); // R9

endmodule

bind varfile varfile_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .NAME_W (NAME_W),
    .BIAS   (BIAS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .name_byte (name_byte),
    .temp_val  (temp_val),
    .index_o   (index_o),
    .rd_data   (rd_data)
);

// File: tb/varfile_test.sv
module varfile_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd = 2'b00;
    logic [7:0]  name_byte = 8'h00;
    logic [15:0] temp_val = 16'h0000;
    logic [4:0]  index_o;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] model [32];

    always #5 clk = ~clk;

    varfile uut (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .name_byte (name_byte),
        .temp_val  (temp_val),
        .index_o   (index_o),
        .rd_data   (rd_data)
    );

    function automatic logic [7:0] name_for(input int idx);
        return 8'(((idx + 'h40) * 2) & 'hFF);
    endfunction

    function automatic logic [4:0] decode(input logic [7:0] nb);
        return 5'((int'(nb) / 2 - 'h40) & 31);
    endfunction

    function automatic logic [15:0] pattern(input int i, input int salt);
        return 16'((i * 'h0101) ^ 'hA5C3 ^ salt);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Inputs change just after a falling edge; one rising edge follows; sampling at the next falling edge.
    task automatic step(input logic [1:0] c, input logic [7:0] nb, input logic [15:0] tv);
        cmd = c;
        name_byte = nb;
        temp_val = tv;
        @(negedge clk);
        cmd = 2'b00;
    endtask

    task automatic select(input int idx);
        step(2'b01, name_for(idx), 16'hDEAD);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", "index after reset", 32'(index_o), 32'd0);
        for (int i = 0; i < 32; i++) begin
            select(i);
            check("R1", "entry zero after reset", 32'(rd_data), 32'd0);
        end

        // R2 decode of every name byte
        for (int b = 0; b < 256; b++) begin
            step(2'b01, 8'(b), 16'h0);
            check("R2", "decoded index", 32'(index_o), 32'(decode(8'(b))));
        end
        step(2'b01, 8'h82, 16'h0);
        check("R2", "letter A", 32'(index_o), 32'd1);
        step(2'b01, 8'hB4, 16'h0);
        check("R2", "letter Z", 32'(index_o), 32'd26);

        // R4 R7 R8: fill every entry, including the unused ones, then read all back
        for (int i = 0; i < 32; i++) begin
            select(i);
            step(2'b10, 8'h00, pattern(i, 0));
            model[i] = pattern(i, 0);
            check("R4", "readback after write", 32'(rd_data), 32'(model[i]));
        end
        for (int i = 0; i < 32; i++) begin
            select(i);
            check((i == 0 || i > 26) ? "R7" : "R8", "entry contents", 32'(rd_data), 32'(model[i]));
        end

        // R3 R9: hold with noisy inputs changes nothing
        select(9);
        for (int k = 0; k < 8; k++) begin
            step(2'b00, 8'(k * 37 + 5), 16'(k * 4099 + 1));
            check("R3", "index under hold", 32'(index_o), 32'd9);
            check("R9", "data under hold", 32'(rd_data), 32'(model[9]));
        end

        // R6: read follows the index with no delay
        select(14);
        check("R6", "read at new index", 32'(rd_data), 32'(model[14]));
        cmd = 2'b01;
        name_byte = name_for(20);
        @(posedge clk);
        #1;
        cmd = 2'b00;
        check("R6", "read right after edge", 32'(rd_data), 32'(model[20]));
        @(negedge clk);

        // R5: combined command writes at old index, loads new index
        for (int t = 0; t < 32; t++) begin
            int o;
            int nw;
            o = t;
            nw = (t * 7 + 3) & 31;
            select(o);
            step(2'b11, name_for(nw), pattern(t, 'h3C3C));
            model[o] = pattern(t, 'h3C3C);
            check("R5", "index after combined", 32'(index_o), 32'(nw));
            check("R5", "new entry after combined", 32'(rd_data), 32'(model[nw]));
            select(o);
            check("R5", "old entry got write", 32'(rd_data), 32'(model[o]));
        end

        // R8 final sweep
        for (int i = 0; i < 32; i++) begin
            select(i);
            check("R8", "final contents", 32'(rd_data), 32'(model[i]));
        end

        // R1 reset again clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "index after second reset", 32'(index_o), 32'd0);
        for (int i = 0; i < 32; i++) begin
            select(i);
            check("R1", "entry after second reset", 32'(rd_data), 32'd0);
        end

        finish_run();
    end

endmodule